// File: doc/BRIEF.md
# Serial Register-Port Slave

This block lets an external serial master reach a bank of 8-bit registers over a framed four-wire serial link, or over a half-duplex three-wire link in which read data returns on the shared data line. A transaction opens when the chip-select input falls and closes when it rises. The first byte shifted in is a command, made of a direction flag, a step flag and a 6-bit register index. One or more data bytes follow, most significant bit first. When the step flag is set, the register index advances by one after each data byte.

All serial inputs are oversampled on the fast system clock through a short synchronizer chain. Toward the core the block offers a plain register-file port: an address, write data, a one-cycle write strobe, combinational read data and a one-cycle read strobe. The read strobe lets registers with side effects on read respond to each access. Serial timing follows mode 3. The serial clock rests high between frames. The slave changes its output after a falling serial-clock edge, and the master samples on the rising edge.

Top module: `spi_regport`

## Requirements
- R1: While chip-select is high, both output enables are low, no strobe fires, and the bit framing returns to the start of a command byte.
- R2: The eight bits after chip-select falls form the command, sampled on rising serial-clock edges and sent MSb first. Bit 7 (sent first) is the direction: 1 reads, 0 writes. Bit 6 is the step flag. Bits 5..0 are the register index.
- R3: A write of one register takes 16 serial clocks. `reg_we` pulses for exactly one system cycle after the eighth data bit, carrying the index from the command and the received byte.
- R4: In a multi-byte write with step flag 1, each byte goes to the next index, and index 63 wraps to 0. With step flag 0, every byte goes to the same index. `reg_addr` holds steady during each write strobe.
- R5: In a read, `reg_re` pulses once when the command byte completes. The register byte is driven from the falling edge that starts bit 8, MSb first. `reg_we` and `reg_re` are never high together.
- R6: In a multi-byte read, `reg_re` pulses again after every data byte, at the next index when the step flag is 1 and at the same index when it is 0. One frame of N read bytes therefore gives N+1 read strobes.
- R7: Output enables stay low throughout the command byte and during any write frame.
- R8: With `three_wire_en` high, read data appears on `spi_sdio_o` under `spi_sdio_oe`, and `spi_sdo_oe` stays low. With it low, `spi_sdo`/`spi_sdo_oe` are used and `spi_sdio_oe` stays low. The two enables are never high together.
- R9: A chip-select rise part-way through a byte discards that byte with no write strobe, and the next frame decodes its first byte as a fresh command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the master, high when idle |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_sdi | input | 1 | Serial data in (also the shared line in three-wire mode) |
| three_wire_en | input | 1 | 1 selects half-duplex three-wire operation |
| spi_sdo | output | 1 | Four-wire serial data out |
| spi_sdo_oe | output | 1 | Output enable for `spi_sdo` |
| spi_sdio_o | output | 1 | Data driven onto the shared line in three-wire mode |
| spi_sdio_oe | output | 1 | Output enable for the shared line |
| reg_addr | output | AW | Register index toward the register file |
| reg_wdata | output | DW | Write data toward the register file |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | DW | Combinational read data for `reg_addr` |
| reg_re | output | 1 | One-cycle read strobe |

## Verification
On every cycle, the assertions check several invariants. Each strobe lasts exactly one cycle, and the two strobes never overlap. The address holds still while a write strobe is high. The output drivers release after chip-select rises and stay quiet before the command ends. The two pin enables are mutually exclusive. Other behaviour shows only in the bench's directed frames. These include the decoding of the command bits, bit order on the wire, index stepping and the 63-to-0 wrap, the exact number of read strobes per frame, and the discarding of a cut-off byte followed by a clean new command.

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int AW          = 6,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sck,
  input  logic          spi_cs_n,
  input  logic          spi_sdi,
  input  logic          three_wire_en,
  output logic          spi_sdo,
  output logic          spi_sdo_oe,
  output logic          spi_sdio_o,
  output logic          spi_sdio_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  input  logic [DW-1:0] reg_rdata,
  output logic          reg_re
);
  localparam int BCW = $clog2(DW);

  logic [SYNC_STAGES-1:0] sck_sr, csn_sr, sdi_sr;
  logic                   sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sr <= '1;
      csn_sr <= '1;
      sdi_sr <= '0;
      sck_d  <= 1'b1;
    end else begin
      sck_sr <= {sck_sr[SYNC_STAGES-2:0], spi_sck};
      csn_sr <= {csn_sr[SYNC_STAGES-2:0], spi_cs_n};
      sdi_sr <= {sdi_sr[SYNC_STAGES-2:0], spi_sdi};
      sck_d  <= sck_sr[SYNC_STAGES-1];
    end
  end

  wire sck_s     = sck_sr[SYNC_STAGES-1];
  wire cs_idle   = csn_sr[SYNC_STAGES-1];
  wire sdi_s     = sdi_sr[SYNC_STAGES-1];
  wire sck_rise  = sck_s & ~sck_d;
  wire sck_fall  = ~sck_s & sck_d;

  logic [BCW-1:0] bitcnt;
  logic [DW-2:0]  shreg;
  logic           in_data, rw_q, ms_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q, txreg;
  logic           we_q, re_q, dout_q, drive_q;

  wire [DW-1:0] byte_in   = {shreg, sdi_s};
  wire          byte_done = sck_rise & ~cs_idle & (bitcnt == BCW'(DW-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt  <= '0;
      shreg   <= '0;
      in_data <= 1'b0;
      rw_q    <= 1'b0;
      ms_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      txreg   <= '0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      dout_q  <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      if (we_q && ms_q) addr_q <= addr_q + AW'(1);
      if (re_q) txreg <= reg_rdata;
      if (cs_idle) begin
        bitcnt  <= '0;
        in_data <= 1'b0;
        drive_q <= 1'b0;
      end else begin
        if (sck_rise) begin
          shreg  <= byte_in[DW-2:0];
          bitcnt <= bitcnt + BCW'(1);
        end
        if (byte_done) begin
          if (!in_data) begin
            in_data <= 1'b1;
            rw_q    <= byte_in[DW-1];
            ms_q    <= byte_in[DW-2];
            addr_q  <= byte_in[AW-1:0];
            re_q    <= byte_in[DW-1];
          end else if (rw_q) begin
            addr_q <= addr_q + AW'(ms_q);
            re_q   <= 1'b1;
          end else begin
            we_q    <= 1'b1;
            wdata_q <= byte_in;
          end
        end
        if (sck_fall && in_data && rw_q) begin
          drive_q <= 1'b1;
          dout_q  <= txreg[DW-1];
          txreg   <= {txreg[DW-2:0], 1'b0};
        end
      end
    end
  end

  assign reg_addr    = addr_q;
  assign reg_wdata   = wdata_q;
  assign reg_we      = we_q;
  assign reg_re      = re_q;
  assign spi_sdo     = dout_q;
  assign spi_sdio_o  = dout_q;
  assign spi_sdo_oe  = drive_q & ~three_wire_en;
  assign spi_sdio_oe = drive_q & three_wire_en;

  assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> !(spi_sdo_oe || spi_sdio_oe));
  assert_we_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  assert_we_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $stable(reg_addr));
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));
  assert_re_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);
  assert_cmd_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_data |-> !drive_q);
  assert_pin_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(spi_sdo_oe && spi_sdio_oe));
endmodule

// File: tb/spi_regport_tb_top.sv
module spi_regport_tb_top;
  localparam int HALF = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic sck = 1'b1, csn = 1'b1, sdi = 1'b0, tw = 1'b0;
  logic sdo, sdo_oe, sdio_o, sdio_oe, reg_we, reg_re;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  spi_regport dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(csn), .spi_sdi(sdi),
    .three_wire_en(tw), .spi_sdo(sdo), .spi_sdo_oe(sdo_oe), .spi_sdio_o(sdio_o),
    .spi_sdio_oe(sdio_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .reg_re(reg_re));

  logic [7:0] mem [64];
  int we_cnt = 0, re_cnt = 0;
  logic [5:0] we_a [16];
  logic [7:0] we_d [16];
  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 8'(i * 7 + 3);
    end else begin
      if (reg_we) begin
        mem[reg_addr] <= reg_wdata;
        we_a[we_cnt % 16] <= reg_addr;
        we_d[we_cnt % 16] <= reg_wdata;
        we_cnt <= we_cnt + 1;
      end
      if (reg_re) re_cnt <= re_cnt + 1;
    end
  end

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  logic [7:0] txb [8];
  logic [7:0] rxb [8];
  int cmd_oe_hits, data_oe_hits, wrong_pin_hits, post_oe;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic spi_run(input int nbytes, input int extra_bits);
    int total;
    total = nbytes * 8 + extra_bits;
    cmd_oe_hits = 0; data_oe_hits = 0; wrong_pin_hits = 0;
    @(negedge clk) csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < total; b++) begin
      sck = 1'b0;
      sdi = txb[b / 8][7 - (b % 8)];
      repeat (HALF) @(negedge clk);
      if (b < 8) cmd_oe_hits += int'(sdo_oe | sdio_oe);
      else begin
        data_oe_hits   += int'(tw ? sdio_oe : sdo_oe);
        wrong_pin_hits += int'(tw ? sdo_oe : sdio_oe);
        rxb[b / 8][7 - (b % 8)] = tw ? sdio_o : sdo;
      end
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    csn = 1'b1;
    repeat (4 * HALF) @(negedge clk);
    post_oe = int'(sdo_oe | sdio_oe);
  endtask

  task automatic t_reset();
    chk("R1 reset sdo_oe", int'(sdo_oe), 0);
    chk("R1 reset sdio_oe", int'(sdio_oe), 0);
    chk("R1 reset strobes", int'(reg_we | reg_re), 0);
  endtask

  task automatic t_single_write();
    int w0;
    w0 = we_cnt;
    txb[0] = 8'h12; txb[1] = 8'hA5;
    spi_run(2, 0);
    chk("R3 single write count", we_cnt - w0, 1);
    chk("R2 write index", int'(we_a[w0 % 16]), 'h12);
    chk("R3 write data", int'(we_d[w0 % 16]), 'hA5);
    chk("R7 no drive in write", cmd_oe_hits + data_oe_hits, 0);
  endtask

  task automatic t_burst_write();
    int w0;
    w0 = we_cnt;
    txb[0] = 8'h7E; txb[1] = 8'h11; txb[2] = 8'h22; txb[3] = 8'h33;
    spi_run(4, 0);
    chk("R4 step count", we_cnt - w0, 3);
    chk("R4 step idx0", int'(we_a[w0 % 16]), 62);
    chk("R4 step idx1", int'(we_a[(w0 + 1) % 16]), 63);
    chk("R4 wrap idx2", int'(we_a[(w0 + 2) % 16]), 0);
    w0 = we_cnt;
    txb[0] = 8'h05; txb[1] = 8'h77; txb[2] = 8'h88;
    spi_run(3, 0);
    chk("R4 fixed idx0", int'(we_a[w0 % 16]), 5);
    chk("R4 fixed idx1", int'(we_a[(w0 + 1) % 16]), 5);
    chk("R4 fixed data", int'(we_d[(w0 + 1) % 16]), 'h88);
  endtask

  task automatic t_single_read();
    int r0;
    r0 = re_cnt;
    txb[0] = 8'h92; txb[1] = 8'h00;
    spi_run(2, 0);
    chk("R5 read data", int'(rxb[1]), 'hA5);
    chk("R5 read strobes", re_cnt - r0, 2);
    chk("R7 quiet command", cmd_oe_hits, 0);
    chk("R5 drive during data", data_oe_hits, 8);
    chk("R8 other pin idle", wrong_pin_hits, 0);
    chk("R1 release after frame", post_oe, 0);
  endtask

  task automatic t_burst_read();
    int r0;
    r0 = re_cnt;
    txb[0] = 8'hFE; txb[1] = 0; txb[2] = 0; txb[3] = 0;
    spi_run(4, 0);
    chk("R6 step byte0", int'(rxb[1]), 'h11);
    chk("R6 step byte1", int'(rxb[2]), 'h22);
    chk("R6 wrap byte2", int'(rxb[3]), 'h33);
    chk("R6 strobe count", re_cnt - r0, 4);
    txb[0] = 8'h85;
    spi_run(3, 0);
    chk("R6 fixed byte0", int'(rxb[1]), 'h88);
    chk("R6 fixed byte1", int'(rxb[2]), 'h88);
  endtask

  task automatic t_three_wire();
    tw = 1'b1;
    txb[0] = 8'h92; txb[1] = 0;
    spi_run(2, 0);
    chk("R8 3-wire data", int'(rxb[1]), 'hA5);
    chk("R8 shared pin enabled", data_oe_hits, 8);
    chk("R8 4-wire pin idle", wrong_pin_hits, 0);
    tw = 1'b0;
  endtask

  task automatic t_abort();
    int w0;
    w0 = we_cnt;
    txb[0] = 8'h20; txb[1] = 8'hFF;
    spi_run(1, 5);
    chk("R9 no strobe on cut byte", we_cnt - w0, 0);
    chk("R1 release after abort", post_oe, 0);
    txb[0] = 8'hA0; txb[1] = 0;
    spi_run(2, 0);
    chk("R9 target untouched", int'(rxb[1]), 'hE3);
    w0 = we_cnt;
    txb[0] = 8'h21; txb[1] = 8'h5A;
    spi_run(2, 0);
    chk("R9 fresh command idx", int'(we_a[w0 % 16]), 'h21);
    chk("R9 fresh command data", int'(we_d[w0 % 16]), 'h5A);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_single_write();
    t_burst_write();
    t_single_read();
    t_burst_read();
    t_three_wire();
    t_abort();
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule